// File: doc/BRIEF.md
# SPI Message Transfer Sequencer

This block runs SPI messages on top of a byte-level serial engine. A message starts with a header that gives the mode bits and the target bit rate. One or more transfer descriptors follow, each giving a byte count, whether outgoing bytes come from the stream, whether incoming bytes are wanted, a settle delay in microseconds, a flag that asks for chip select to be released after the transfer, and a flag that marks the final transfer. From the header the sequencer derives the engine's configuration and its two 3-bit baud fields. It then drives chip select and moves bytes one at a time. Outgoing bytes come from a valid/ready stream, and incoming bytes leave on a valid pulse.

The engine reports each byte in one of three ways: completed, write collision or mode fault. On a collision the sequencer writes the same byte again. On a mode fault it abandons the message. After the last byte of a transfer, the sequencer counts out the settle delay, then either fetches the next descriptor or closes the message. When a message ends, a one-cycle completion pulse carries an error flag and the number of bytes in the transfers that finished.

Top module: `spi_msg_seq`

## Requirements
- R1: When a header is accepted (`msg_valid` high in the idle state), the next cycle shows `eng_master`, `eng_enable` and `eng_irq_en` high, `eng_cpha` equal to `msg_mode[0]`, `eng_cpol` equal to `msg_mode[1]` and `eng_lsb_first` equal to `msg_mode[2]`.
- R2: The baud fields follow this rule. Start with P = (CLK_HZ / speed + 1) >> 1, with a floor of 1. While P-1 > 7, replace P with (P+1) >> 1 and add one to the exponent S. Then `eng_prescale` = P-1 and `eng_exp` = S. If S exceeds 7, or the speed is 0, both fields are 7.
- R3: `cs_n` goes low in the cycle a descriptor is accepted, before that transfer's first write, and stays low on every engine write.
- R4: Every byte written to the engine is the next `tx_data` byte when the transfer's tx flag is set, and zero when it is clear. Exactly the descriptor's length in bytes is written, not counting retries.
- R5: When the engine reports a completed byte, `rx_valid` pulses with `rx_data` equal to `eng_rdata` only if the transfer's rx flag is set. Otherwise no rx pulse appears.
- R6: After `eng_wcol`, the same byte is written again on the next cycle, and the remaining byte count does not change.
- R7: After `eng_modf` (with no collision), `cs_n` goes high, `msg_done` pulses with `msg_err` = 1 and `msg_len` = the bytes of the transfers that completed earlier, and a new header is accepted next.
- R8: After the completion of a transfer's last byte, the sequencer waits `xd_delay_us`*CYC_PER_US cycles before acting. The final transfer's `msg_done` appears delay+2 cycles after the cycle in which `eng_done` was high.
- R9: Between transfers, `cs_n` rises (for at least one cycle) only if the finished transfer's drop flag was set.
- R10: After the final transfer's delay, `cs_n` goes high and `msg_done` pulses with `msg_err` = 0 and `msg_len` equal to the sum of all transfer lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message header offered |
| msg_ready | output | 1 | Sequencer idle, header accepted |
| msg_mode | input | 3 | bit0 clock phase, bit1 clock polarity, bit2 LSB first |
| msg_speed | input | SPD_W | Target bit rate in Hz (0 gives slowest) |
| xd_valid | input | 1 | Transfer descriptor offered |
| xd_ready | output | 1 | Descriptor accepted |
| xd_len | input | LEN_W | Bytes in the transfer |
| xd_tx_en | input | 1 | Outgoing bytes come from the tx stream |
| xd_rx_en | input | 1 | Incoming bytes are delivered |
| xd_delay_us | input | US_W | Settle delay after the transfer, in microseconds |
| xd_cs_drop | input | 1 | Release chip select after this transfer |
| xd_last | input | 1 | Final transfer of the message |
| tx_valid | input | 1 | Outgoing byte available |
| tx_ready | output | 1 | Outgoing byte taken |
| tx_data | input | 8 | Outgoing byte |
| rx_valid | output | 1 | Incoming byte pulse |
| rx_data | output | 8 | Incoming byte |
| eng_master | output | 1 | Engine master mode |
| eng_enable | output | 1 | Engine enable |
| eng_irq_en | output | 1 | Engine event enable |
| eng_cpol | output | 1 | Clock polarity |
| eng_cpha | output | 1 | Clock phase |
| eng_lsb_first | output | 1 | Bit order |
| eng_prescale | output | 3 | Baud prescale field |
| eng_exp | output | 3 | Baud exponent field |
| eng_wr | output | 1 | Byte write strobe |
| eng_wdata | output | 8 | Byte to send |
| eng_done | input | 1 | Byte completed |
| eng_rdata | input | 8 | Byte received |
| eng_wcol | input | 1 | Write collision |
| eng_modf | input | 1 | Mode fault |
| cs_n | output | 1 | Chip select, active low |
| msg_done | output | 1 | Message completion pulse |
| msg_err | output | 1 | Completion carried an error |
| msg_len | output | ACT_W | Bytes of completed transfers |

## Verification
The bench injects collisions at random byte positions. A design that moved on after a collision, or resent a different byte, would give a longer or shorter byte log. A mode fault is forced inside the second transfer of a message, and the bench expects only the first transfer's length and a prompt return to idle. A design that kept chip select low or counted the partial transfer fails that case. The wait after the final byte is measured to the exact cycle for delays from zero upward, which catches an off-by-one in the countdown. The baud rule is checked at speeds where the fields are 0/0, at random speeds, and at speeds that force the 7/7 clamp.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_SEND,
      ST_AWAIT,
      ST_DELAY
   } seq_state_e;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned BAUD_FIELD_W = 3;
endpackage

// File: rtl/spi_seq_baud.sv
module spi_seq_baud #(
   parameter int unsigned CLK_HZ = 33_000_000,
   parameter int unsigned SPD_W  = 32
) (
   input  logic [SPD_W-1:0] speed,
   output logic [2:0]       prescale,
   output logic [2:0]       expo
);
   localparam int unsigned PW    = 34;
   localparam int unsigned STEPS = PW;

   if (SPD_W > 32) begin : g_bad_width
      $error("spi_seq_baud: SPD_W must not exceed 32");
   end

   logic [PW-1:0] quo;
   logic [PW-1:0] p;
   logic [5:0]    s;

   always_comb begin
      quo      = '0;
      p        = '0;
      s        = '0;
      prescale = 3'd7;
      expo     = 3'd7;
      if (speed != '0) begin
         quo = PW'(CLK_HZ) / PW'(speed);
         p   = (quo + PW'(1)) >> 1;
         if (p == '0) p = PW'(1);
         for (int i = 0; i < STEPS; i++) begin
            if ((p - PW'(1)) > PW'(7)) begin
               p = (p + PW'(1)) >> 1;
               s = s + 6'd1;
            end
         end
         if (s <= 6'd7) begin
            prescale = p[2:0] - 3'd1;
            expo     = s[2:0];
         end
      end
   end
endmodule

// File: rtl/spi_seq_delay.sv
module spi_seq_delay #(
   parameter int unsigned US_W       = 8,
   parameter int unsigned CYC_PER_US = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [US_W-1:0] us,
   output logic            zero
);
   localparam int unsigned MUL_W = $clog2(CYC_PER_US + 1);
   localparam int unsigned CNT_W = US_W + MUL_W;

   if (CYC_PER_US < 1) begin : g_bad_rate
      $error("spi_seq_delay: CYC_PER_US must be at least 1");
   end

   logic [CNT_W-1:0] start_val;
   logic [CNT_W-1:0] cnt;

   if (CYC_PER_US == 1) begin : g_unit
      assign start_val = CNT_W'(us);
   end else begin : g_scaled
      assign start_val = CNT_W'(us) * CNT_W'(CYC_PER_US);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= start_val;
      else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
   end

   assign zero = (cnt == '0);

   assert_load_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(start_val)));

   assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
endmodule

// File: rtl/spi_msg_seq.sv
module spi_msg_seq
   import spi_seq_pkg::*;
#(
   parameter int unsigned CLK_HZ     = 33_000_000,
   parameter int unsigned SPD_W      = 32,
   parameter int unsigned LEN_W      = 8,
   parameter int unsigned US_W       = 8,
   parameter int unsigned CYC_PER_US = 4,
   parameter int unsigned ACT_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msg_valid,
   output logic             msg_ready,
   input  logic [2:0]       msg_mode,
   input  logic [SPD_W-1:0] msg_speed,
   input  logic             xd_valid,
   output logic             xd_ready,
   input  logic [LEN_W-1:0] xd_len,
   input  logic             xd_tx_en,
   input  logic             xd_rx_en,
   input  logic [US_W-1:0]  xd_delay_us,
   input  logic             xd_cs_drop,
   input  logic             xd_last,
   input  logic             tx_valid,
   output logic             tx_ready,
   input  logic [7:0]       tx_data,
   output logic             rx_valid,
   output logic [7:0]       rx_data,
   output logic             eng_master,
   output logic             eng_enable,
   output logic             eng_irq_en,
   output logic             eng_cpol,
   output logic             eng_cpha,
   output logic             eng_lsb_first,
   output logic [2:0]       eng_prescale,
   output logic [2:0]       eng_exp,
   output logic             eng_wr,
   output logic [7:0]       eng_wdata,
   input  logic             eng_done,
   input  logic [7:0]       eng_rdata,
   input  logic             eng_wcol,
   input  logic             eng_modf,
   output logic             cs_n,
   output logic             msg_done,
   output logic             msg_err,
   output logic [ACT_W-1:0] msg_len
);
   if (ACT_W < LEN_W) begin : g_bad_act
      $error("spi_msg_seq: ACT_W must cover LEN_W");
   end

   seq_state_e       st;
   logic [LEN_W-1:0] x_len, rem;
   logic             x_tx, x_rx, x_drop, x_last;
   logic [US_W-1:0]  x_dly;
   logic [ACT_W-1:0] act, act_sum;
   logic [2:0]       baud_pre, baud_exp;
   logic             tmr_load, tmr_zero;
   logic [US_W-1:0]  tmr_us;
   logic             byte_ok;

   spi_seq_baud #(.CLK_HZ(CLK_HZ), .SPD_W(SPD_W)) u_baud (
      .speed(msg_speed), .prescale(baud_pre), .expo(baud_exp));

   assign byte_ok  = (st == ST_AWAIT) && !eng_wcol && !eng_modf && eng_done;
   assign tmr_load = (byte_ok && rem == LEN_W'(1)) ||
                     (st == ST_FETCH && xd_valid && xd_len == '0);
   assign tmr_us   = (st == ST_FETCH) ? xd_delay_us : x_dly;

   spi_seq_delay #(.US_W(US_W), .CYC_PER_US(CYC_PER_US)) u_delay (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .us(tmr_us), .zero(tmr_zero));

   assign msg_ready = (st == ST_IDLE);
   assign xd_ready  = (st == ST_FETCH);
   assign tx_ready  = (st == ST_SEND) && x_tx;
   assign act_sum   = act + ACT_W'(x_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         cs_n <= 1'b1;
         {eng_master, eng_enable, eng_irq_en} <= '0;
         {eng_cpol, eng_cpha, eng_lsb_first} <= '0;
         eng_prescale <= '0;
         eng_exp <= '0;
         eng_wr <= 1'b0;
         eng_wdata <= '0;
         rx_valid <= 1'b0;
         rx_data <= '0;
         msg_done <= 1'b0;
         msg_err <= 1'b0;
         msg_len <= '0;
         act <= '0;
         rem <= '0;
         x_len <= '0;
         {x_tx, x_rx, x_drop, x_last} <= '0;
         x_dly <= '0;
      end else begin
         eng_wr   <= 1'b0;
         rx_valid <= 1'b0;
         msg_done <= 1'b0;
         unique case (st)
            ST_IDLE: if (msg_valid) begin
               {eng_master, eng_enable, eng_irq_en} <= 3'b111;
               eng_cpha      <= msg_mode[0];
               eng_cpol      <= msg_mode[1];
               eng_lsb_first <= msg_mode[2];
               eng_prescale  <= baud_pre;
               eng_exp       <= baud_exp;
               act           <= '0;
               st            <= ST_FETCH;
            end
            ST_FETCH: if (xd_valid) begin
               x_len  <= xd_len;
               rem    <= xd_len;
               x_tx   <= xd_tx_en;
               x_rx   <= xd_rx_en;
               x_dly  <= xd_delay_us;
               x_drop <= xd_cs_drop;
               x_last <= xd_last;
               cs_n   <= 1'b0;
               st     <= (xd_len == '0) ? ST_DELAY : ST_SEND;
            end
            ST_SEND: if (!x_tx || tx_valid) begin
               eng_wr    <= 1'b1;
               eng_wdata <= x_tx ? tx_data : 8'h00;
               st        <= ST_AWAIT;
            end
            ST_AWAIT: begin
               if (eng_wcol) begin
                  eng_wr <= 1'b1;
               end else if (eng_modf) begin
                  cs_n     <= 1'b1;
                  msg_done <= 1'b1;
                  msg_err  <= 1'b1;
                  msg_len  <= act;
                  st       <= ST_IDLE;
               end else if (eng_done) begin
                  if (x_rx) begin
                     rx_valid <= 1'b1;
                     rx_data  <= eng_rdata;
                  end
                  rem <= rem - LEN_W'(1);
                  st  <= (rem == LEN_W'(1)) ? ST_DELAY : ST_SEND;
               end
            end
            ST_DELAY: if (tmr_zero) begin
               act <= act_sum;
               if (x_last) begin
                  cs_n     <= 1'b1;
                  msg_done <= 1'b1;
                  msg_err  <= 1'b0;
                  msg_len  <= act_sum;
                  st       <= ST_IDLE;
               end else begin
                  if (x_drop) cs_n <= 1'b1;
                  st <= ST_FETCH;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assert_cs_low_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_wr |-> !cs_n);

   assert_retry_same_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_AWAIT && eng_wcol) |=> (eng_wr && $stable(eng_wdata) && $stable(rem)));

   assert_rx_only_when_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ($past(eng_done) && x_rx));

   assert_fault_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_AWAIT && !eng_wcol && eng_modf) |=> (msg_done && msg_err && cs_n && msg_ready));

   assert_done_releases_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      msg_done |-> cs_n);

   assert_single_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({msg_ready, xd_ready, tx_ready}));
endmodule

// File: tb/spi_msg_seq_bench.sv
module spi_msg_seq_bench;
   localparam int unsigned CLK_HZ  = 33_000_000;
   localparam int unsigned CYC     = 4;
   localparam time         CLK_PER = 10ns;

   logic clk = 1'b0, rst_n = 1'b0;
   logic msg_valid = 0, msg_ready;
   logic [2:0] msg_mode = 0;
   logic [31:0] msg_speed = 0;
   logic xd_valid = 0, xd_ready, xd_tx_en = 0, xd_rx_en = 0, xd_cs_drop = 0, xd_last = 0;
   logic [7:0] xd_len = 0, xd_delay_us = 0;
   logic tx_valid = 0, tx_ready;
   logic [7:0] tx_data = 0;
   logic rx_valid;
   logic [7:0] rx_data;
   logic eng_master, eng_enable, eng_irq_en, eng_cpol, eng_cpha, eng_lsb_first;
   logic [2:0] eng_prescale, eng_exp;
   logic eng_wr;
   logic [7:0] eng_wdata;
   logic eng_done = 0, eng_wcol = 0, eng_modf = 0;
   logic [7:0] eng_rdata = 0;
   logic cs_n, msg_done, msg_err;
   logic [15:0] msg_len;

   spi_msg_seq #(.CLK_HZ(CLK_HZ), .SPD_W(32), .LEN_W(8), .US_W(8),
                 .CYC_PER_US(CYC), .ACT_W(16)) u_spi_msg_seq (.*);

   always #(CLK_PER/2) clk = ~clk;

   int checks = 0, errors = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // logs and stimulus state
   logic [7:0] tx_buf[0:63], wr_log[0:63], rx_log[0:63], exp_wr[0:63], exp_rx[0:63];
   int tx_cnt = 0, tx_idx = 0, wr_n = 0, rx_n = 0, cs_rise = 0, cs_bad = 0;
   int eng_wn = 0, wcol_at = 0, modf_at = 0, t_last_done = 0, t_msg_done = 0;
   bit done_seen = 0, done_err = 0, tx_pend = 0, cs_prev = 1;
   int done_len = 0;
   int t_len[0:3], t_dly[0:3];
   bit t_tx[0:3], t_rx[0:3], t_drop[0:3];

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic logic [5:0] ref_baud(input longint spd);
      longint p;
      int s;
      if (spd == 0) return 6'h3F;
      p = ((longint'(CLK_HZ) / spd) + 1) / 2;
      if (p < 1) p = 1;
      s = 0;
      while (p - 1 > 7) begin
         p = (p + 1) / 2;
         s++;
      end
      if (s > 7) return 6'h3F;
      return {3'(p - 1), 3'(s)};
   endfunction

   // engine model
   initial begin
      int cd = 0, kind = 0;
      logic [7:0] last_w = 0;
      forever begin
         @(negedge clk);
         eng_done = 0; eng_wcol = 0; eng_modf = 0;
         if (cd > 0) begin
            cd--;
            if (cd == 0) begin
               if (kind == 1) eng_wcol = 1;
               else if (kind == 2) eng_modf = 1;
               else begin
                  eng_done = 1;
                  eng_rdata = last_w ^ 8'hA5;
                  t_last_done = cyc;
               end
            end
         end
         if (eng_wr) begin
            eng_wn++;
            if (wr_n < 64) wr_log[wr_n] = eng_wdata;
            wr_n++;
            if (cs_n) cs_bad++;
            kind = (eng_wn == wcol_at) ? 1 : (eng_wn == modf_at) ? 2 : 0;
            last_w = eng_wdata;
            cd = 2;
         end
      end
   end

   // tx stream source
   initial forever begin
      @(negedge clk);
      if (tx_pend) tx_idx++;
      tx_pend = tx_valid && tx_ready;
      tx_valid = (tx_idx < tx_cnt);
      tx_data = tx_buf[tx_idx % 64];
   end

   // monitor
   initial forever begin
      @(negedge clk);
      if (rx_valid) begin
         if (rx_n < 64) rx_log[rx_n] = rx_data;
         rx_n++;
      end
      if (cs_n && !cs_prev) cs_rise++;
      cs_prev = cs_n;
      if (msg_done) begin
         done_seen = 1;
         done_err = msg_err;
         done_len = int'(msg_len);
         t_msg_done = cyc;
      end
   end

   task automatic run_msg(input int ntr, input int wc, input int mf, input int unsigned spd,
                          input logic [2:0] mode);
      int ewn = 0, ern = 0, pos = 0, exp_len = 0, exp_rise = 1, mf_len = 0;
      bit mf_hit = 0;
      logic [7:0] b;
      logic [5:0] eb;
      wr_n = 0; rx_n = 0; cs_rise = 0; cs_bad = 0; done_seen = 0;
      eng_wn = 0; wcol_at = wc; modf_at = mf;
      tx_idx = 0; tx_cnt = 0; tx_pend = 0;
      for (int t = 0; t < ntr; t++) begin
         for (int k = 0; k < t_len[t]; k++) begin
            b = t_tx[t] ? 8'($urandom_range(0, 255)) : 8'h00;
            if (t_tx[t]) begin tx_buf[tx_cnt] = b; tx_cnt++; end
            exp_wr[ewn] = b; ewn++; pos++;
            if (pos == mf) mf_hit = 1;
            if (pos == wc) begin exp_wr[ewn] = b; ewn++; end
            if (t_rx[t]) begin exp_rx[ern] = b ^ 8'hA5; ern++; end
         end
         if (!mf_hit) mf_len += t_len[t];
         exp_len += t_len[t];
         if (t < ntr - 1 && t_drop[t]) exp_rise++;
      end
      // header
      msg_mode = mode; msg_speed = spd; msg_valid = 1;
      while (!msg_ready) @(negedge clk);
      @(negedge clk);
      msg_valid = 0;
      eb = ref_baud(longint'(spd));
      chk(eng_master && eng_enable && eng_irq_en, "R1", "master/enable/irq", 0, 1);
      chk({eng_lsb_first, eng_cpol, eng_cpha} == mode, "R1", "mode bits",
          int'({eng_lsb_first, eng_cpol, eng_cpha}), int'(mode));
      chk({eng_prescale, eng_exp} == eb, "R2", "baud fields",
          int'({eng_prescale, eng_exp}), int'(eb));
      // descriptors
      for (int t = 0; t < ntr; t++) begin
         if (!done_seen) begin
            xd_len = 8'(t_len[t]); xd_tx_en = t_tx[t]; xd_rx_en = t_rx[t];
            xd_delay_us = 8'(t_dly[t]); xd_cs_drop = t_drop[t]; xd_last = (t == ntr - 1);
            xd_valid = 1;
            while (!xd_ready && !done_seen) @(negedge clk);
            if (xd_ready) begin
               @(negedge clk);
               chk(!cs_n, "R3", "cs low after descriptor accept", cs_n, 0);
            end
            xd_valid = 0;
         end
      end
      while (!done_seen) @(negedge clk);
      chk(cs_n, "R10", "cs released at completion", cs_n, 1);
      chk(cs_bad == 0, "R3", "writes while cs high", cs_bad, 0);
      if (mf != 0) begin
         chk(done_err, "R7", "fault error status", done_err, 1);
         chk(done_len == mf_len, "R7", "fault length", done_len, mf_len);
         chk(cs_rise == 1, "R7", "cs releases on fault", cs_rise, 1);
      end else begin
         chk(!done_err, "R10", "success status", done_err, 0);
         chk(done_len == exp_len, "R10", "actual length", done_len, exp_len);
         chk(cs_rise == exp_rise, "R9", "cs release count", cs_rise, exp_rise);
         chk(wr_n == ewn, "R6", "write count incl retries", wr_n, ewn);
         for (int i = 0; i < ewn && i < wr_n; i++)
            chk(wr_log[i] == exp_wr[i], "R4", "written byte", wr_log[i], exp_wr[i]);
         chk(rx_n == ern, "R5", "rx byte count", rx_n, ern);
         for (int i = 0; i < ern && i < rx_n; i++)
            chk(rx_log[i] == exp_rx[i], "R5", "rx byte", rx_log[i], exp_rx[i]);
         chk(t_msg_done - t_last_done == t_dly[ntr-1] * CYC + 2, "R8", "final delay gap",
             t_msg_done - t_last_done, t_dly[ntr-1] * CYC + 2);
      end
      repeat (3) @(negedge clk);
      chk(msg_ready, "R7", "back to idle", msg_ready, 1);
   endtask

   task automatic set_xfer(input int t, input int len, input bit tx, input bit rx,
                           input int dly, input bit drop);
      t_len[t] = len; t_tx[t] = tx; t_rx[t] = rx; t_dly[t] = dly; t_drop[t] = drop;
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(cs_n && msg_ready && !msg_done && !eng_wr && !rx_valid, "R3", "reset state", cs_n, 1);

      // directed: fastest speed, tx+rx, drop between transfers, zero delay
      set_xfer(0, 2, 1, 1, 0, 1); set_xfer(1, 1, 1, 0, 0, 0);
      run_msg(2, 0, 0, CLK_HZ, 3'b101);
      // directed: clamp by slow speed, no tx no rx, collision on first write (R6)
      set_xfer(0, 3, 0, 0, 2, 0);
      run_msg(1, 1, 0, 1000, 3'b010);
      // directed: zero speed clamps (R2), cs kept low across transfers (R9)
      set_xfer(0, 1, 1, 1, 1, 0); set_xfer(1, 2, 1, 1, 0, 0); set_xfer(2, 1, 0, 1, 1, 1);
      run_msg(3, 0, 0, 0, 3'b000);
      // directed: mode fault in the second transfer (R7)
      set_xfer(0, 2, 1, 1, 0, 0); set_xfer(1, 3, 1, 1, 0, 0);
      run_msg(2, 0, 3, CLK_HZ / 20, 3'b011);
      // directed: fault on the very first write
      set_xfer(0, 2, 1, 0, 0, 0);
      run_msg(1, 0, 1, 5_000_000, 3'b111);

      for (int m = 0; m < 24; m++) begin
         int ntr, total, wc;
         ntr = $urandom_range(1, 3);
         total = 0;
         for (int t = 0; t < ntr; t++) begin
            set_xfer(t, $urandom_range(1, 4), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     $urandom_range(0, 2), 1'($urandom_range(0, 1)));
            total += t_len[t];
         end
         wc = ($urandom_range(0, 2) == 0) ? $urandom_range(1, total) : 0;
         run_msg(ntr, wc, 0, $urandom_range(1000, 40_000_000), 3'($urandom_range(0, 7)));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule